// File: doc/BRIEF.md
# Bus-Organized Register File Datapath

This block is the execute core of a small processor. Seven general-purpose registers, GP1 to GP7, sit behind two read multiplexers that feed the A and B operands of a single shared ALU. Each clock, one 14-bit micro-operation word does three things: it picks both operands, it picks the operation, and it picks which register, if any, captures the result on the next rising edge.

Either operand can also be taken from an external input bus. This is how values enter the register set. The ALU result always appears on the output bus, with zero, sign and carry/borrow flags beside it. This lets a sequencer read a register out by transferring it with no write.

Instruction fetch, sequencing, memory access and generation of the control word all belong to the surrounding logic. The data width is a parameter.

Top module: `regbus_datapath`

## Requirements
- R1: An active-low reset (asserted asynchronously, released on the clock) clears GP1 to GP7 to zero.
- R2: The control word is packed with the A-select in bits [13:11], the B-select in bits [10:8], the destination select in bits [7:5] and the operation code in bits [4:0].
- R3: A source select of 000 takes `data_in` as that operand; a select of 001 to 111 takes GP1 to GP7.
- R4: A destination select of 001 to 111 loads the result into GP1 to GP7 on the rising clock edge; a select of 000 leaves every register unchanged.
- R5: The arithmetic operation codes behave as follows: 00000 passes A; 00001 gives A+1; 00010 gives A+B; 00101 gives A-B, formed as A plus the two's complement of B; 00110 gives A-1. All results wrap modulo 2^W.
- R6: The logic operation codes behave as follows: 01000 gives A AND B; 01010 gives A OR B; 01100 gives A XOR B; 01110 gives NOT A.
- R7: Code 10000 shifts A right by one place and code 11000 shifts A left by one place. In both cases the vacated bit is filled with zero.
- R8: `flag_carry` depends on the operation. For add and increment it is the carry out. For subtract it is the borrow (A<B). For decrement it is the borrow (A==0). For a right shift it is the bit shifted out of A[0], and for a left shift it is the bit shifted out of A[W-1]. For every other code it is 0.
- R9: `flag_zero` is 1 exactly when the current result is zero. `flag_sign` equals the result's most significant bit.
- R10: Any code not listed in R5 to R7 produces a zero result and writes no register.
- R11: A register that is both a source and the destination is read with its old value, and takes the new value at the clock edge.
- R12: `result_out` always presents the current combinational ALU result, whether or not a register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_word | input | 14 | Micro-operation word |
| data_in | input | DATA_W | External operand bus |
| result_out | output | DATA_W | Current ALU result |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Result MSB |
| flag_carry | output | 1 | Carry or borrow |

## Verification
The hardest case to reach from the ports is a register that is read and written in the same cycle, combined with every operation code, while the register contents are not trivial. Register state is visible only by routing it through the ALU.

The bench sweeps every combination of operation code, A-select, B-select and destination. It starts with the transfer code, so that input-bus values spread into all seven registers before the other codes run. The bench keeps its own register model, updated only at clock edges. Every vector therefore checks the previous writes, the no-write case and the undefined codes through the result bus.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int SEL_W  = 3;
  localparam int OPR_W  = 5;
  localparam int NREG   = (1 << SEL_W) - 1;
  localparam int CTRL_W = 3 * SEL_W + OPR_W;

  typedef enum logic [OPR_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dest;
    logic [OPR_W-1:0] opcode;
  } uop_t;
endpackage

// File: rtl/regbus_regfile.sv
module regbus_regfile
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NREG:1][DATA_W-1:0] regs_o
);
  logic [NREG:1][DATA_W-1:0] regs_q;
  logic [NREG:1][DATA_W-1:0] regs_d;
  logic [NREG:1]             reg_ce;

  // Per-register clock enables, one decoder leg per register.
  genvar g;
  generate
    for (g = 1; g <= NREG; g++) begin : g_ce
      assign reg_ce[g] = wr_en && (wr_idx == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    regs_d = regs_q;
    for (int k = 1; k <= NREG; k++) begin
      if (reg_ce[k]) regs_d[k] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign regs_o = regs_q;

  // R4
  nowrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> regs_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/regbus_opsel.sv
module regbus_opsel
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [SEL_W-1:0]          sel,
  input  logic [DATA_W-1:0]         ext_in,
  input  logic [NREG:1][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]         operand_o
);
  always_comb begin
    operand_o = ext_in;
    for (int k = 1; k <= NREG; k++) begin
      if (sel == SEL_W'(k)) operand_o = regs_i[k];
    end
  end
endmodule

// File: rtl/regbus_alu.sv
module regbus_alu
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPR_W-1:0]  opcode,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              valid_o
);
  localparam int EXT_W = DATA_W + 1;
  logic [EXT_W-1:0] sum;

  always_comb begin
    sum     = '0;
    res_o   = '0;
    carry_o = 1'b0;
    valid_o = 1'b1;
    case (opcode)
      OP_PASS: res_o = a_i;
      OP_INC: begin
        sum = {1'b0, a_i} + EXT_W'(1);
        res_o = sum[DATA_W-1:0]; carry_o = sum[DATA_W];
      end
      OP_ADD: begin
        sum = {1'b0, a_i} + {1'b0, b_i};
        res_o = sum[DATA_W-1:0]; carry_o = sum[DATA_W];
      end
      OP_SUB: begin
        sum = {1'b0, a_i} + {1'b0, ~b_i} + EXT_W'(1);
        res_o = sum[DATA_W-1:0]; carry_o = ~sum[DATA_W];
      end
      OP_DEC: begin
        sum = {1'b0, a_i} + {1'b0, {DATA_W{1'b1}}};
        res_o = sum[DATA_W-1:0]; carry_o = ~sum[DATA_W];
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_NOT: res_o = ~a_i;
      OP_SHR: begin
        res_o = {1'b0, a_i[DATA_W-1:1]}; carry_o = a_i[0];
      end
      OP_SHL: begin
        res_o = {a_i[DATA_W-2:0], 1'b0}; carry_o = a_i[DATA_W-1];
      end
      default: valid_o = 1'b0;
    endcase
  end

  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (res_o == '0 && !carry_o));

  // R7
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opcode == OP_SHR |-> !res_o[DATA_W-1]);

  // R7
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opcode == OP_SHL |-> !res_o[0]);

  // R8
  logic_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR || opcode == OP_NOT)
      |-> !carry_o);
endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       ctrl_word,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] result_out,
  output logic              flag_zero,
  output logic              flag_sign,
  output logic              flag_carry
);
  uop_t                      uop;
  logic [NREG:1][DATA_W-1:0] regs;
  logic [DATA_W-1:0]         a_bus;
  logic [DATA_W-1:0]         b_bus;
  logic [DATA_W-1:0]         alu_res;
  logic                      alu_carry;
  logic                      alu_valid;
  logic                      wr_en;

  assign uop = uop_t'(ctrl_word);

  regbus_opsel #(.DATA_W(DATA_W)) u_sel_a (
    .sel(uop.src_a), .ext_in(data_in), .regs_i(regs), .operand_o(a_bus));

  regbus_opsel #(.DATA_W(DATA_W)) u_sel_b (
    .sel(uop.src_b), .ext_in(data_in), .regs_i(regs), .operand_o(b_bus));

  regbus_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst_n(rst_n), .opcode(uop.opcode), .a_i(a_bus), .b_i(b_bus),
    .res_o(alu_res), .carry_o(alu_carry), .valid_o(alu_valid));

  assign wr_en = alu_valid && (uop.dest != '0);

  regbus_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(uop.dest),
    .wr_data(alu_res), .regs_o(regs));

  assign result_out = alu_res;
  assign flag_zero  = (alu_res == '0);
  assign flag_sign  = alu_res[DATA_W-1];
  assign flag_carry = alu_carry;

  // R3
  ext_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop.src_a == '0 && uop.opcode == OP_PASS |-> result_out == data_in);

  // R10
  undef_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_valid |=> $stable(regs));
endmodule

// File: tb/regbus_datapath_tb.sv
module regbus_datapath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [13:0]  ctrl = '0;
  logic [W-1:0] din = '0;
  logic [W-1:0] res;
  logic         fz, fs, fc;

  regbus_datapath #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .data_in(din),
    .result_out(res), .flag_zero(fz), .flag_sign(fs), .flag_carry(fc));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;
  int model [1:7];

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: returns valid, carry, result (computed arithmetically).
  task automatic ref_alu(input int op, input int a, input int b,
                         output bit valid, output int c, output int r);
    valid = 1'b1; c = 0; r = 0;
    case (op)
      0:  r = a;                                              // R5 pass
      1:  begin r = (a + 1) & MASK; c = (a == MASK); end      // R5 inc
      2:  begin r = (a + b) & MASK; c = (a + b) > MASK; end   // R5 add
      5:  begin r = (a - b) & MASK; c = (a < b); end          // R5 sub
      6:  begin r = (a - 1) & MASK; c = (a == 0); end         // R5 dec
      8:  r = a & b;                                          // R6
      10: r = a | b;
      12: r = a ^ b;
      14: r = (~a) & MASK;
      16: begin r = a >> 1; c = a & 1; end                    // R7
      24: begin r = (a << 1) & MASK; c = (a >> (W-1)) & 1; end
      default: valid = 1'b0;                                  // R10
    endcase
  endtask

  function automatic string op_tag(int op);
    case (op)
      0, 1, 2, 5, 6: return "R5";
      8, 10, 12, 14: return "R6";
      16, 24:        return "R7";
      default:       return "R10";
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin : stim
    int a, b, r, c, lfsr;
    bit v;
    for (int k = 1; k <= 7; k++) model[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every register reads zero after reset (transfer, no write).
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      ctrl = {3'(k), 3'b000, 3'b000, 5'b00000};
      #1 chk("R1", int'(res), 0);
    end

    // Full sweep. R2 field packing, R3 source selects, R4 dest and no-write,
    // R11 same source/destination, R12 output with no write, R8/R9 flags.
    lfsr = 8'h5b;
    for (int op = 0; op < 32; op++)
      for (int sa = 0; sa < 8; sa++)
        for (int sb = 0; sb < 8; sb++)
          for (int sd = 0; sd < 8; sd++) begin
            @(negedge clk);
            lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & MASK;
            din  = W'(lfsr);
            ctrl = {3'(sa), 3'(sb), 3'(sd), 5'(op)};
            #1;
            a = (sa == 0) ? lfsr : model[sa];
            b = (sb == 0) ? lfsr : model[sb];
            ref_alu(op, a, b, v, c, r);
            chk(op_tag(op), int'(res), r);
            chk("R8", int'(fc), c);
            chk("R9", int'(fz), (r == 0) ? 1 : 0);
            chk("R9", int'(fs), (r >> (W-1)) & 1);
            @(posedge clk);
            if (v && sd != 0) model[sd] = r;
          end

    // R4 / R12: final readback of every register with no write.
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      ctrl = {3'(k), 3'b000, 3'b000, 5'b00000};
      #1 chk("R4", int'(res), model[k]);
    end

    // R1: reset in mid-run clears state again.
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      ctrl = {3'(k), 3'b000, 3'b000, 5'b00000};
      #1 chk("R1", int'(res), 0);
    end
    report();
  end
endmodule